// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the serial clock level for an I2C master. It holds a 7-bit down counter that is advanced by two phase strobes in each instruction cycle. A write to the transmit buffer loads the counter from the low bits of a reload register and starts the count. Each time a strobe finds the counter at zero, the block emits a one-cycle rollover pulse, toggles the SCL drive level and reloads the counter.

While an operation is running, reloads happen automatically. When the surrounding byte engine reports that the operation has finished, counting stops and SCL keeps its current level until the next buffer write. One SCL period spans two rollovers, so the SCL rate is the instruction-cycle rate divided by (reload + 1). For example, at a 10 MHz instruction rate a reload of 18h gives 400 kHz, 1Fh gives 312.5 kHz and 63h gives 100 kHz. At 1 MHz, a reload of 00h gives 1 MHz.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `roll_o` is 0, `scl_o` is 1 and the counter is idle. Phase strobes cause no rollover until a buffer write arrives.
- R2: A `buf_wr` pulse loads the counter from `reload_val[6:0]` and starts counting at once. `reload_val[7]` has no effect on timing.
- R3: While running, the counter decrements by one on each cycle where `phase_a` or `phase_b` is high. No other cycle changes it.
- R4: A strobe that finds the count at zero causes three things. `roll_o` is high for exactly the next cycle. `scl_o` inverts on that same cycle. The counter reloads from `reload_val[6:0]`.
- R5: With reload N, consecutive SCL transitions are N+1 strobes apart. With two strobes per 4-clock instruction cycle, each SCL half period is 2(N+1) clocks and the full period is N+1 instruction cycles.
- R6: A reload of 0 gives a rollover on every strobe, so SCL toggles every 2 clocks under the standard strobe pattern.
- R7: An `op_done` pulse stops counting. No rollover follows it and `scl_o` holds its level until the next `buf_wr`. A strobe in the same cycle as `op_done` is ignored.
- R8: When `buf_wr` coincides with `op_done` or with a strobe, the load wins: the counter takes the reload value, the block runs, and no decrement or rollover happens in that cycle.
- R9: A change to `reload_val` during a count has no effect on the count in progress. It is used at the next load or rollover reload.
- R10: A `buf_wr` while already running restarts the count from the current reload value and leaves `scl_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phase_a | input | 1 | First count strobe of the instruction cycle |
| phase_b | input | 1 | Second count strobe of the instruction cycle |
| reload_val | input | 8 | Reload register; only the low 7 bits are used |
| buf_wr | input | 1 | Transmit buffer write strobe; loads and starts the counter |
| op_done | input | 1 | Operation finished strobe; stops counting |
| roll_o | output | 1 | One-cycle pulse on each counter rollover |
| scl_o | output | 1 | SCL drive level |

## Verification
The bench builds the block with the default 8-bit reload register, so the full 7-bit reload range and the ignored top bit are both reachable. It drives the standard two-strobes-per-4-clock pattern, which makes the SCL half period a direct clock count of 2(N+1). It measures that period for reloads 00h, 02h, 09h (written with bit 7 set) and 18h. Each run also exercises mid-count reload changes, restarts, stops, and coincident load/stop/strobe cycles against a cycle-level reference model.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_t;
endpackage

// File: rtl/scl_run_ctl.sv
module scl_run_ctl
  import scl_gen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic buf_wr,
  input  logic op_done,
  output logic load,
  output logic tick
);
  run_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (buf_wr)       state_d = RUN_BUSY;
    else if (op_done) state_d = RUN_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RUN_IDLE;
    else        state_q <= state_d;
  end

  // load has priority; a stop or a load masks the strobe
  assign load = buf_wr;
  assign tick = (state_q == RUN_BUSY) && strobe && !buf_wr && !op_done;
endmodule

// File: rtl/scl_down_ctr.sv
module scl_down_ctr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             zero_hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;
  logic             cnt_en;

  assign at_zero  = (cnt_q == '0);
  assign zero_hit = tick && at_zero;
  assign cnt_en   = load || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (load)          cnt_d = reload;
    else if (zero_hit) cnt_d = reload;
    else if (tick)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_level.sv
module scl_level (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_hit,
  output logic roll_o,
  output logic scl_o
);
  logic roll_q, roll_d;
  logic scl_q, scl_d;

  always_comb begin
    roll_d = zero_hit;
    scl_d  = scl_q ^ zero_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roll_q <= 1'b0;
      scl_q  <= 1'b1;
    end else begin
      roll_q <= roll_d;
      scl_q  <= scl_d;
    end
  end

  assign roll_o = roll_q;
  assign scl_o  = scl_q;
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic [REG_W-1:0] reload_val,
  input  logic             buf_wr,
  input  logic             op_done,
  output logic             roll_o,
  output logic             scl_o
);
  localparam int CNT_W = REG_W - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             strobe;
  logic             load;
  logic             tick;
  logic             zero_hit;
  logic [CNT_W-1:0] reload;
  logic             unused_reload_msb;

  assign strobe            = phase_a | phase_b;
  assign reload            = reload_val[CNT_W-1:0];
  assign unused_reload_msb = reload_val[REG_W-1];

  scl_run_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .strobe  (strobe),
    .buf_wr  (buf_wr),
    .op_done (op_done),
    .load    (load),
    .tick    (tick)
  );

  scl_down_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (load),
    .tick     (tick),
    .reload   (reload),
    .zero_hit (zero_hit)
  );

  scl_level u_lvl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .zero_hit (zero_hit),
    .roll_o   (roll_o),
    .scl_o    (scl_o)
  );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic phase_a,
  input logic phase_b,
  input logic buf_wr,
  input logic op_done,
  input logic roll_o,
  input logic scl_o
);
  // R4: SCL only moves on a rollover cycle
  assert_scl_moves_on_roll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_o) |-> roll_o);

  // R4: every rollover moves SCL
  assert_roll_moves_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |-> !$stable(scl_o));

  // R3: a rollover needs a strobe in the previous cycle
  assert_roll_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase_a || phase_b) |=> !roll_o);

  // R7: no rollover right after a stop
  assert_no_roll_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !roll_o);

  // R8: a load cycle never rolls over
  assert_load_no_roll_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> !roll_o);
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .phase_a (phase_a),
  .phase_b (phase_b),
  .buf_wr  (buf_wr),
  .op_done (op_done),
  .roll_o  (roll_o),
  .scl_o   (scl_o)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  logic       clk;
  logic       rst_n;
  logic       phase_a, phase_b;
  logic [7:0] reload_val;
  logic       buf_wr, op_done;
  logic       roll_o, scl_o;

  scl_rate_gen dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_a    (phase_a),
    .phase_b    (phase_b),
    .reload_val (reload_val),
    .buf_wr     (buf_wr),
    .op_done    (op_done),
    .roll_o     (roll_o),
    .scl_o      (scl_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_vec  = 0;
  int n_fail = 0;
  bit done_run = 0;
  string cur_req = "R1";

  // reference model state
  bit       m_run;
  bit [6:0] m_cnt;
  bit       m_scl;
  int       q_phase;

  logic [1:0] exp_q[$];   // {roll, scl}

  // period measurement
  int  cyc = 0;
  bit  meas_en = 0;
  bit  have_last = 0;
  int  meas_n = 0;
  int  last_t = 0;
  logic last_scl = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // driver: one clock of stimulus, pushes expected outputs after the edge
  task automatic step(input bit bw, input bit od);
    bit pa, pb, strb, roll;
    pa = (q_phase == 1);
    pb = (q_phase == 3);
    q_phase = (q_phase + 1) % 4;
    phase_a = pa; phase_b = pb;
    buf_wr = bw;  op_done = od;
    strb = pa | pb;
    roll = 0;
    if (bw) begin
      m_cnt = reload_val[6:0];
      m_run = 1;
    end else if (od) begin
      m_run = 0;
    end else if (m_run && strb) begin
      if (m_cnt == 0) begin
        roll  = 1;
        m_scl = ~m_scl;
        m_cnt = reload_val[6:0];
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
    @(posedge clk);
    #1;
    exp_q.push_back({roll, m_scl});
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      e = exp_q.pop_front();
      check(cur_req, roll_o, e[1], "roll_o");
      check(cur_req, scl_o,  e[0], "scl_o");
    end
    if (rst_n && scl_o !== last_scl) begin
      if (meas_en && have_last)
        check("R5", cyc - last_t, 2 * (meas_n + 1), "half period clocks");
      last_t    = cyc;
      have_last = 1;
    end
    last_scl = scl_o;
  end

  task automatic measure(input logic [7:0] rv, input int halves, input string req);
    cur_req    = req;
    reload_val = rv;
    meas_n     = int'(rv[6:0]);
    have_last  = 0;
    meas_en    = 1;
    step(1, 0);
    run(2 * (meas_n + 1) * (halves + 1) + 2);
    meas_en = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done_run) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; phase_a = 0; phase_b = 0; buf_wr = 0; op_done = 0;
    reload_val = 8'h05;
    m_run = 0; m_cnt = 0; m_scl = 1; q_phase = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", roll_o, 0, "roll_o after reset");
    check("R1", scl_o, 1, "scl_o after reset");
    cur_req = "R1";
    run(20);                       // strobes while idle: nothing moves

    measure(8'h18, 3, "R5");       // 400 kHz at 10 MHz instr rate
    measure(8'h89, 3, "R2");       // bit 7 ignored -> reload 9
    measure(8'h00, 4, "R6");       // rollover every strobe
    measure(8'h02, 3, "R5");

    // R9: reload change mid-count
    cur_req = "R9";
    reload_val = 8'h06;
    step(1, 0);
    run(5);
    reload_val = 8'h0B;
    run(60);

    // R10: restart while running
    cur_req = "R10";
    run(7);
    reload_val = 8'h03;
    step(1, 0);
    run(30);

    // R7: stop mid count, SCL holds
    cur_req = "R7";
    step(0, 1);
    run(40);
    // R7: stop on strobe cycle with count at zero
    reload_val = 8'h00;
    step(1, 0);
    run(3);
    step(0, 1);
    run(12);

    // R8: load beats stop and strobe in same cycle
    cur_req = "R8";
    reload_val = 8'h01;
    step(1, 1);
    run(9);
    step(1, 0);
    step(1, 0);
    run(10);

    // R3/R4: general running with a different reload
    cur_req = "R4";
    reload_val = 8'h04;
    step(1, 0);
    run(50);
    step(0, 1);
    run(4);

    done_run = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule